// File: doc/BRIEF.md
# Set-Associative Address Translation Cache

This block caches virtual-page to physical-frame translations for a requester that cannot afford a page walk on every access. Entries are grouped into sets of ways; the set is picked by the lowest bits of the virtual page number, and every way of that set is compared in parallel against the page number together with a process identifier. A hit returns the physical address, which is the stored frame joined with the page offset of the request. A miss returns a plain miss flag after a programmable delay. The requester resolves the miss elsewhere and then writes the translation in through the fill port.

Each lookup carries a recency flag. When the flag is clear, the lookup is a functional probe that leaves the replacement order untouched. Each lookup also carries the access attributes: privilege level, a force-supervisor flag, write intent and a prefetch tag. On a demand hit these drive a protection check. A prefetch-tagged lookup skips the check and returns the translation even when a demand access to the same page would fault. A single-cycle flush input empties the whole cache and resets the replacement order.

Top module: `xc_tlb`

## Requirements
- R1: The cache has ENTRIES/WAYS sets (WAYS and ENTRIES powers of two, WAYS <= ENTRIES). The set index is virtual address bits [PAGE_BITS +: log2(sets)]. Fills into one set never displace entries of another set.
- R2: A lookup hits only when a valid way in its set holds the same full virtual page number and the same process identifier. A different identifier, or a different page mapping to the same set, misses.
- R3: A fill whose page number and identifier are already present rewrites that way with the new frame and permissions. It never creates a second copy, so the other resident pages stay resident.
- R4: A fill into a set with an empty way uses an empty way. A fill into a full set replaces the least recently used way of that set. Both fills and recency-updating hits count as uses.
- R5: An accepted lookup (lk_valid and lk_ready high at a rising edge) that hits shows rsp_valid=1 with rsp_hit=1 after that same edge, and lk_ready stays high.
- R6: An accepted lookup that misses holds lk_ready low and rsp_valid low for MISS_LAT-1 cycles. It then shows rsp_valid=1 with rsp_hit=0, rsp_fault=0 and rsp_paddr=0, MISS_LAT cycles after acceptance.
- R7: A hit with lk_touch=1 makes the entry most recently used. A hit with lk_touch=0 leaves the replacement order exactly as it was.
- R8: flush invalidates every entry in one cycle and resets the replacement order. When flush and a fill arrive in the same cycle, the flush wins and the fill is dropped.
- R9: On a hit without a fault, rsp_paddr = {stored frame number, lk_vaddr[PAGE_BITS-1:0]}.
- R10: An access is user mode when lk_priv==3 and lk_force_sup==0. A demand hit faults when a user-mode access reaches a page whose user-allowed bit is 0, or when a write (lk_write=1) reaches a page whose writable bit is 0. A fault response has rsp_hit=1, rsp_fault=1 and rsp_paddr=0.
- R11: A lookup with lk_prefetch=1 never faults. On a hit it returns the translated address even when the same access without the prefetch tag would fault.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| flush | input | 1 | Invalidate all entries |
| lk_valid | input | 1 | Lookup request present |
| lk_ready | output | 1 | Lookup can be accepted |
| lk_vaddr | input | VA_W | Virtual address to translate |
| lk_pid | input | PID_W | Process identifier of the request |
| lk_touch | input | 1 | Hit updates recency when 1 |
| lk_write | input | 1 | Access is a write |
| lk_priv | input | 2 | Privilege level, 3 is least privileged |
| lk_force_sup | input | 1 | Treat the access as supervisor |
| lk_prefetch | input | 1 | Prefetch access, no protection check |
| rsp_valid | output | 1 | Response present |
| rsp_hit | output | 1 | Translation found |
| rsp_fault | output | 1 | Protection violation |
| rsp_paddr | output | PA_W | Translated physical address |
| ins_valid | input | 1 | Fill request |
| ins_vpn | input | VA_W-PAGE_BITS | Virtual page number to fill |
| ins_pid | input | PID_W | Process identifier of the fill |
| ins_pfn | input | PA_W-PAGE_BITS | Physical frame number to fill |
| ins_user_ok | input | 1 | Page may be used from user mode |
| ins_wr_ok | input | 1 | Page may be written |

## Verification
A hit result is due after the very edge that accepts the lookup. A miss result is due MISS_LAT-1 edges later, and lk_ready is low in between. The bench drives every request on a falling edge and samples on the following falling edges. It checks each intermediate cycle of a miss for a low lk_ready and a low rsp_valid, and checks the response fields only on the cycle the response is due. On every falling edge it also flags any response that appears while none is outstanding. Fills and flushes take effect at the edge that samples them, so the reference model applies them at that edge, before the next lookup is driven.

// File: rtl/xc_pkg.sv
// Shared types for the translation cache.
// Assumes: nothing beyond IEEE 1800-2017.
package xc_pkg;

    // Permission bits held with every cached translation.
    typedef struct packed {
        logic user_ok;   // page reachable from user mode
        logic wr_ok;     // page writable
    } xc_perm_t;

    // Privilege level that counts as user mode.
    localparam logic [1:0] XC_PRIV_USER = 2'd3;

endpackage

// File: rtl/xc_way_match.sv
// Parallel tag compare over the ways of one set.
// Assumes: at most one valid way matches (the fill path keeps tags unique),
// so the encoded way is meaningful whenever hit is high.
module xc_way_match #(
    parameter int WAYS  = 4,
    parameter int TAG_W = 24,
    parameter int WAY_W = 2
) (
    input  logic [WAYS-1:0][TAG_W-1:0] tags,
    input  logic [WAYS-1:0]            vld,
    input  logic [TAG_W-1:0]           key,
    output logic [WAYS-1:0]            hit_vec,
    output logic                       hit,
    output logic [WAY_W-1:0]           hit_way
);

    // One comparator per way.
    for (genvar w = 0; w < WAYS; w++) begin : g_cmp
        assign hit_vec[w] = vld[w] && (tags[w] == key);
    end

    assign hit = |hit_vec;

    // Encode the matching way into an index.
    always_comb begin
        hit_way = '0;
        for (int w = 0; w < WAYS; w++) begin
            if (hit_vec[w]) hit_way = WAY_W'(w);
        end
    end

endmodule

// File: rtl/xc_age_tracker.sv
// Recency order of the ways of one set, kept as one age per way.
// Age 0 is most recent and WAYS-1 is the oldest. The ages always form a
// permutation of 0..WAYS-1, so exactly one way carries the oldest age.
// Assumes: one touch per cycle; clear has priority over touch.
module xc_age_tracker #(
    parameter int WAYS  = 4,
    parameter int WAY_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             touch_en,
    input  logic [WAY_W-1:0] touch_way,
    output logic [WAY_W-1:0] oldest_way
);

    logic [WAY_W-1:0] age_q [WAYS];

    // Age update: reset or clear to way order, a touch moves a way to age 0.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            for (int w = 0; w < WAYS; w++) age_q[w] <= WAY_W'(w);
        end else if (touch_en) begin
            for (int w = 0; w < WAYS; w++) begin
                if (WAY_W'(w) == touch_way)
                    age_q[w] <= '0;
                else if (age_q[w] < age_q[touch_way])
                    age_q[w] <= age_q[w] + 1'b1;
            end
        end
    end

    // Find the way that carries the oldest age.
    always_comb begin
        oldest_way = '0;
        for (int w = 0; w < WAYS; w++) begin
            if (age_q[w] == WAY_W'(WAYS - 1)) oldest_way = WAY_W'(w);
        end
    end

endmodule

// File: rtl/xc_perm_check.sv
// Protection check for one demand access against the permissions of a page.
// Assumes: the caller gates the result with the hit of the same lookup.
module xc_perm_check
    import xc_pkg::*;
(
    input  logic       [1:0] priv,
    input  logic             force_sup,
    input  logic             is_write,
    input  logic             prefetch,
    input  xc_perm_t         perm,
    output logic             fault
);

    logic user_mode;
    logic violation;

    // User mode unless the request forces supervisor treatment.
    assign user_mode = (priv == XC_PRIV_USER) && !force_sup;

    // Either rule may be broken; prefetches never report it.
    assign violation = (user_mode && !perm.user_ok) || (is_write && !perm.wr_ok);
    assign fault     = !prefetch && violation;

endmodule

// File: rtl/xc_tlb.sv
// Set-associative virtual-to-physical translation cache.
// Lookups compare {pid, vpn} across the ways of one set. A hit answers after
// the accepting edge; a miss stalls the port and answers MISS_LAT cycles after
// acceptance. Fills pick: the matching way, else the lowest empty way, else the
// oldest way. Assumes ENTRIES and WAYS are powers of two, WAYS <= ENTRIES,
// MISS_LAT >= 1. A fill and a recency-updating hit to the same set in the same
// cycle: the fill's recency update is the one kept.
module xc_tlb
    import xc_pkg::*;
#(
    parameter int ENTRIES   = 16,
    parameter int WAYS      = 4,
    parameter int VA_W      = 32,
    parameter int PA_W      = 32,
    parameter int PAGE_BITS = 12,
    parameter int PID_W     = 4,
    parameter int MISS_LAT  = 3
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      flush,
    input  logic                      lk_valid,
    output logic                      lk_ready,
    input  logic [VA_W-1:0]           lk_vaddr,
    input  logic [PID_W-1:0]          lk_pid,
    input  logic                      lk_touch,
    input  logic                      lk_write,
    input  logic [1:0]                lk_priv,
    input  logic                      lk_force_sup,
    input  logic                      lk_prefetch,
    output logic                      rsp_valid,
    output logic                      rsp_hit,
    output logic                      rsp_fault,
    output logic [PA_W-1:0]           rsp_paddr,
    input  logic                      ins_valid,
    input  logic [VA_W-PAGE_BITS-1:0] ins_vpn,
    input  logic [PID_W-1:0]          ins_pid,
    input  logic [PA_W-PAGE_BITS-1:0] ins_pfn,
    input  logic                      ins_user_ok,
    input  logic                      ins_wr_ok
);

    localparam int SETS   = ENTRIES / WAYS;
    localparam int SET_W  = (SETS > 1) ? $clog2(SETS) : 1;
    localparam int WAY_W  = (WAYS > 1) ? $clog2(WAYS) : 1;
    localparam int IDX_W  = SET_W + WAY_W;
    localparam int VPN_W  = VA_W - PAGE_BITS;
    localparam int PFN_W  = PA_W - PAGE_BITS;
    localparam int TAG_W  = PID_W + VPN_W;
    localparam int CNT_W  = (MISS_LAT > 1) ? $clog2(MISS_LAT) : 1;
    localparam logic [SET_W-1:0] SET_MASK = SET_W'(SETS - 1);

    // ---------------- storage ----------------
    logic [TAG_W-1:0] tag_q  [ENTRIES];
    logic [PFN_W-1:0] pfn_q  [ENTRIES];
    xc_perm_t         perm_q [ENTRIES];
    logic [ENTRIES-1:0] vld_q;

    // ---------------- lookup side ----------------
    logic [VPN_W-1:0]            lk_vpn;
    logic [SET_W-1:0]            lk_set;
    logic [TAG_W-1:0]            lk_key;
    logic [WAYS-1:0][TAG_W-1:0]  lk_tags;
    logic [WAYS-1:0]             lk_vld;
    logic [WAYS-1:0]             lk_hit_vec;
    logic                        lk_hit;
    logic [WAY_W-1:0]            lk_hit_way;
    logic [IDX_W-1:0]            lk_idx;
    logic                        lk_accept;
    logic                        lk_touch_fire;
    logic                        lk_fault_raw;
    logic                        lk_fault;
    logic [PA_W-1:0]             lk_paddr;

    assign lk_vpn = lk_vaddr[VA_W-1:PAGE_BITS];
    assign lk_set = lk_vpn[SET_W-1:0] & SET_MASK;
    assign lk_key = {lk_pid, lk_vpn};

    // Gather the tag image of the looked-up set.
    always_comb begin
        for (int w = 0; w < WAYS; w++) begin
            lk_tags[w] = tag_q[{lk_set, WAY_W'(w)}];
            lk_vld[w]  = vld_q[{lk_set, WAY_W'(w)}];
        end
    end

    xc_way_match #(.WAYS(WAYS), .TAG_W(TAG_W), .WAY_W(WAY_W)) i_lk_match (
        .tags    (lk_tags),
        .vld     (lk_vld),
        .key     (lk_key),
        .hit_vec (lk_hit_vec),
        .hit     (lk_hit),
        .hit_way (lk_hit_way)
    );

    assign lk_idx        = {lk_set, lk_hit_way};
    assign lk_accept     = lk_valid && lk_ready;
    assign lk_touch_fire = lk_accept && lk_hit && lk_touch;

    xc_perm_check i_perm (
        .priv      (lk_priv),
        .force_sup (lk_force_sup),
        .is_write  (lk_write),
        .prefetch  (lk_prefetch),
        .perm      (perm_q[lk_idx]),
        .fault     (lk_fault_raw)
    );

    assign lk_fault = lk_hit && lk_fault_raw;
    assign lk_paddr = (lk_hit && !lk_fault) ?
                      {pfn_q[lk_idx], lk_vaddr[PAGE_BITS-1:0]} : '0;

    // ---------------- fill side ----------------
    logic [SET_W-1:0]            ins_set;
    logic [TAG_W-1:0]            ins_key;
    logic [WAYS-1:0][TAG_W-1:0]  in_tags;
    logic [WAYS-1:0]             in_vld;
    logic [WAYS-1:0]             in_hit_vec;
    logic                        in_hit;
    logic [WAY_W-1:0]            in_hit_way;
    logic [WAY_W-1:0]            in_free_way;
    logic [WAY_W-1:0]            in_victim;
    logic [IDX_W-1:0]            ins_idx;
    logic [WAY_W-1:0]            set_oldest [SETS];

    assign ins_set = ins_vpn[SET_W-1:0] & SET_MASK;
    assign ins_key = {ins_pid, ins_vpn};

    // Gather the tag image of the filled set.
    always_comb begin
        for (int w = 0; w < WAYS; w++) begin
            in_tags[w] = tag_q[{ins_set, WAY_W'(w)}];
            in_vld[w]  = vld_q[{ins_set, WAY_W'(w)}];
        end
    end

    xc_way_match #(.WAYS(WAYS), .TAG_W(TAG_W), .WAY_W(WAY_W)) i_in_match (
        .tags    (in_tags),
        .vld     (in_vld),
        .key     (ins_key),
        .hit_vec (in_hit_vec),
        .hit     (in_hit),
        .hit_way (in_hit_way)
    );

    // Lowest-numbered empty way of the filled set.
    always_comb begin
        in_free_way = '0;
        for (int w = WAYS - 1; w >= 0; w--) begin
            if (!in_vld[w]) in_free_way = WAY_W'(w);
        end
    end

    // Way choice: rewrite a match, else take an empty way, else evict the oldest.
    always_comb begin
        if (in_hit)
            in_victim = in_hit_way;
        else if (!(&in_vld))
            in_victim = in_free_way;
        else
            in_victim = set_oldest[ins_set];
    end

    assign ins_idx = {ins_set, in_victim};

    // One recency tracker per set; a fill's touch beats a lookup's touch.
    for (genvar s = 0; s < SETS; s++) begin : g_set
        logic ins_here;
        logic lk_here;
        assign ins_here = ins_valid && (ins_set == SET_W'(s));
        assign lk_here  = lk_touch_fire && (lk_set == SET_W'(s));

        xc_age_tracker #(.WAYS(WAYS), .WAY_W(WAY_W)) i_age (
            .clk        (clk),
            .rst_n      (rst_n),
            .clear      (flush),
            .touch_en   (ins_here || lk_here),
            .touch_way  (ins_here ? in_victim : lk_hit_way),
            .oldest_way (set_oldest[s])
        );
    end

    // Entry array write: reset and flush empty it, a fill writes one way.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld_q <= '0;
            for (int e = 0; e < ENTRIES; e++) begin
                tag_q[e]  <= '0;
                pfn_q[e]  <= '0;
                perm_q[e] <= '0;
            end
        end else if (flush) begin
            vld_q <= '0;
        end else if (ins_valid) begin
            vld_q[ins_idx]  <= 1'b1;
            tag_q[ins_idx]  <= ins_key;
            pfn_q[ins_idx]  <= ins_pfn;
            perm_q[ins_idx] <= '{user_ok: ins_user_ok, wr_ok: ins_wr_ok};
        end
    end

    // ---------------- response ----------------
    logic             rsp_pend_q;
    logic [CNT_W-1:0] wait_q;
    logic             hit_q;
    logic             fault_q;
    logic [PA_W-1:0]  paddr_q;

    // Response register and miss-delay counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_pend_q <= 1'b0;
            wait_q     <= '0;
            hit_q      <= 1'b0;
            fault_q    <= 1'b0;
            paddr_q    <= '0;
        end else if (lk_accept) begin
            rsp_pend_q <= 1'b1;
            hit_q      <= lk_hit;
            fault_q    <= lk_fault;
            paddr_q    <= lk_paddr;
            wait_q     <= lk_hit ? '0 : CNT_W'(MISS_LAT - 1);
        end else if (rsp_pend_q) begin
            if (wait_q != '0)
                wait_q <= wait_q - 1'b1;
            else
                rsp_pend_q <= 1'b0;
        end
    end

    assign rsp_valid = rsp_pend_q && (wait_q == '0);
    assign lk_ready  = !(rsp_pend_q && (wait_q != '0));
    assign rsp_hit   = hit_q;
    assign rsp_fault = fault_q;
    assign rsp_paddr = paddr_q;

endmodule

// File: rtl/xc_tlb_chk.sv
// Property checker for the translation cache, bound into every xc_tlb.
// Assumes: it sees the top ports and the two per-set match vectors.
module xc_tlb_chk #(
    parameter int WAYS = 4,
    parameter int PA_W = 32
) (
    input logic            clk,
    input logic            rst_n,
    input logic            flush,
    input logic            lk_valid,
    input logic            lk_ready,
    input logic            lk_prefetch,
    input logic            rsp_valid,
    input logic            rsp_hit,
    input logic            rsp_fault,
    input logic [PA_W-1:0] rsp_paddr,
    input logic [WAYS-1:0] lk_hit_vec,
    input logic [WAYS-1:0] in_hit_vec
);

    // R5: an accepted hit answers right after the accepting edge.
    a_r5_hit_next_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_valid && lk_ready && (|lk_hit_vec)) |=> (rsp_valid && rsp_hit && lk_ready));

    // R5 and R6: the port never stalls while a response is shown.
    a_r5_no_rsp_while_stalled: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_ready |-> !rsp_valid);

    // R6: an accepted miss leaves no hit flag behind.
    a_r6_miss_reports_miss: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_valid && lk_ready && !(|lk_hit_vec)) |=> !rsp_hit);

    // R6: a miss response carries no fault and no address.
    a_r6_miss_clean: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_hit) |-> (!rsp_fault && (rsp_paddr == '0)));

    // R10: a fault response is a hit with no address.
    a_r10_fault_no_addr: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_fault) |-> (rsp_hit && (rsp_paddr == '0)));

    // R11: a prefetch never produces a fault.
    a_r11_prefetch_no_fault: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_valid && lk_ready && lk_prefetch) |=> !rsp_fault);

    // R8: right after a flush nothing can hit.
    a_r8_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_valid && lk_ready && $past(flush)) |-> !(|lk_hit_vec));

    // R3: fills never leave two ways holding the same page.
    a_r3_unique_lookup: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(lk_hit_vec));
    a_r3_unique_fill: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(in_hit_vec));

endmodule

bind xc_tlb xc_tlb_chk #(.WAYS(WAYS), .PA_W(PA_W)) i_xc_tlb_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .flush       (flush),
    .lk_valid    (lk_valid),
    .lk_ready    (lk_ready),
    .lk_prefetch (lk_prefetch),
    .rsp_valid   (rsp_valid),
    .rsp_hit     (rsp_hit),
    .rsp_fault   (rsp_fault),
    .rsp_paddr   (rsp_paddr),
    .lk_hit_vec  (lk_hit_vec),
    .in_hit_vec  (in_hit_vec)
);

// File: tb/test_xc_tlb.sv
`timescale 1ns/1ps
// Self-checking bench with a behavioural reference model (a queue of
// resident pages with use stamps) compared on every clock.
module test_xc_tlb;

    localparam int ENTRIES = 16;
    localparam int WAYS    = 4;
    localparam int SETS    = ENTRIES / WAYS;
    localparam int MISS_LAT = 3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        flush = 1'b0;
    logic        lk_valid = 1'b0;
    logic        lk_ready;
    logic [31:0] lk_vaddr = '0;
    logic [3:0]  lk_pid = '0;
    logic        lk_touch = 1'b0;
    logic        lk_write = 1'b0;
    logic [1:0]  lk_priv = '0;
    logic        lk_force_sup = 1'b0;
    logic        lk_prefetch = 1'b0;
    logic        rsp_valid;
    logic        rsp_hit;
    logic        rsp_fault;
    logic [31:0] rsp_paddr;
    logic        ins_valid = 1'b0;
    logic [19:0] ins_vpn = '0;
    logic [3:0]  ins_pid = '0;
    logic [19:0] ins_pfn = '0;
    logic        ins_user_ok = 1'b0;
    logic        ins_wr_ok = 1'b0;

    int checks = 0;
    int errors = 0;
    bit expect_rsp = 1'b0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    xc_tlb #(.ENTRIES(ENTRIES), .WAYS(WAYS), .VA_W(32), .PA_W(32),
             .PAGE_BITS(12), .PID_W(4), .MISS_LAT(MISS_LAT)) i_xc_tlb (
        .clk(clk), .rst_n(rst_n), .flush(flush),
        .lk_valid(lk_valid), .lk_ready(lk_ready), .lk_vaddr(lk_vaddr),
        .lk_pid(lk_pid), .lk_touch(lk_touch), .lk_write(lk_write),
        .lk_priv(lk_priv), .lk_force_sup(lk_force_sup), .lk_prefetch(lk_prefetch),
        .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_fault(rsp_fault),
        .rsp_paddr(rsp_paddr), .ins_valid(ins_valid), .ins_vpn(ins_vpn),
        .ins_pid(ins_pid), .ins_pfn(ins_pfn), .ins_user_ok(ins_user_ok),
        .ins_wr_ok(ins_wr_ok)
    );

    // ---------------- reference model ----------------
    typedef struct {
        int vpn; int pid; int pfn; bit u; bit w; int stamp;
    } ment_t;
    ment_t mq[$];
    int    use_stamp = 0;

    function automatic int m_find(int vpn, int pid);
        foreach (mq[i]) if (mq[i].vpn == vpn && mq[i].pid == pid) return i;
        return -1;
    endfunction

    function automatic void m_insert(int vpn, int pid, int pfn, bit u, bit w);
        int idx;
        int cnt;
        int old;
        ment_t e;
        idx = m_find(vpn, pid);
        use_stamp++;
        if (idx >= 0) begin
            mq[idx].pfn = pfn; mq[idx].u = u; mq[idx].w = w;
            mq[idx].stamp = use_stamp;
            return;
        end
        cnt = 0; old = -1;
        foreach (mq[i]) if (mq[i].vpn % SETS == vpn % SETS) begin
            cnt++;
            if (old < 0 || mq[i].stamp < mq[old].stamp) old = i;
        end
        if (cnt == WAYS) mq.delete(old);
        e.vpn = vpn; e.pid = pid; e.pfn = pfn; e.u = u; e.w = w; e.stamp = use_stamp;
        mq.push_back(e);
    endfunction

    // ---------------- check helpers ----------------
    task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    // Every clock: no response may appear unless one is outstanding (R5, R6).
    always @(negedge clk) begin
        if (rst_n && !done) begin
            checks++;
            if (rsp_valid && !expect_rsp) begin
                errors++;
                $display("FAIL R6 unsolicited response: actual rsp_valid 1 expected 0");
            end
        end
    end

    task automatic do_insert(int vpn, int pid, int pfn, bit u, bit w);
        ins_valid = 1'b1; ins_vpn = 20'(vpn); ins_pid = 4'(pid);
        ins_pfn = 20'(pfn); ins_user_ok = u; ins_wr_ok = w;
        @(posedge clk);
        m_insert(vpn, pid, pfn, u, w);
        @(negedge clk);
        ins_valid = 1'b0;
    endtask

    task automatic do_flush();
        flush = 1'b1;
        @(posedge clk);
        mq.delete();
        @(negedge clk);
        flush = 1'b0;
    endtask

    task automatic do_lookup(int vpn, int off, int pid, bit touch, bit wr,
                             int priv, bit fsup, bit pf, string req);
        int          mi;
        bit          hit;
        bit          user;
        bit          fault;
        logic [31:0] epa;
        mi    = m_find(vpn, pid);
        hit   = (mi >= 0);
        user  = (priv == 3) && !fsup;
        fault = 1'b0;
        epa   = '0;
        if (hit) begin
            fault = !pf && ((user && !mq[mi].u) || (wr && !mq[mi].w));
            if (!fault) epa = {mq[mi].pfn[19:0], 12'(off)};
        end
        chk(req, "ready before request", {31'd0, lk_ready}, 32'd1);
        lk_valid = 1'b1; lk_vaddr = {20'(vpn), 12'(off)}; lk_pid = 4'(pid);
        lk_touch = touch; lk_write = wr; lk_priv = 2'(priv);
        lk_force_sup = fsup; lk_prefetch = pf;
        @(posedge clk);
        expect_rsp = 1'b1;
        if (hit && touch) begin
            use_stamp++;
            mq[mi].stamp = use_stamp;
        end
        @(negedge clk);
        lk_valid = 1'b0;
        if (!hit) begin
            for (int c = 1; c < MISS_LAT; c++) begin
                chk(req, "miss wait rsp_valid", {31'd0, rsp_valid}, 32'd0);
                chk(req, "miss wait lk_ready", {31'd0, lk_ready}, 32'd0);
                @(negedge clk);
            end
        end
        chk(req, "rsp_valid", {31'd0, rsp_valid}, 32'd1);
        chk(req, "rsp_hit", {31'd0, rsp_hit}, {31'd0, hit});
        chk(req, "rsp_fault", {31'd0, rsp_fault}, {31'd0, fault});
        chk(req, "rsp_paddr", rsp_paddr, epa);
        @(posedge clk);
        expect_rsp = 1'b0;
        @(negedge clk);
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // Reset state (R5, R6).
        chk("R5", "reset lk_ready", {31'd0, lk_ready}, 32'd1);
        chk("R6", "reset rsp_valid", {31'd0, rsp_valid}, 32'd0);

        // Empty cache misses (R6).
        do_lookup('h10, 'h345, 1, 1, 0, 0, 0, 0, "R6");
        // Fill then hit with address join (R9, R5).
        do_insert('h10, 1, 'hABC, 1, 1);
        do_lookup('h10, 'h345, 1, 1, 0, 0, 0, 0, "R9");
        do_lookup('h10, 'hFFF, 1, 1, 0, 3, 0, 0, "R5");
        // Identifier and page must both match (R2).
        do_lookup('h10, 'h001, 2, 1, 0, 0, 0, 0, "R2");
        do_lookup('h14, 'h001, 1, 1, 0, 0, 0, 0, "R2");
        // Rewrite of a resident page (R3).
        do_insert('h10, 1, 'h111, 1, 1);
        do_lookup('h10, 'h222, 1, 1, 0, 0, 0, 0, "R3");
        // Fill the rest of set 0 using empty ways (R4), all four stay (R3).
        do_insert('h14, 1, 'h214, 1, 1);
        do_insert('h18, 1, 'h218, 1, 1);
        do_insert('h1C, 1, 'h21C, 1, 1);
        do_lookup('h10, 'h0, 1, 1, 0, 0, 0, 0, "R3");
        do_lookup('h14, 'h0, 1, 1, 0, 0, 0, 0, "R4");
        do_lookup('h18, 'h0, 1, 1, 0, 0, 0, 0, "R4");
        do_lookup('h1C, 'h0, 1, 1, 0, 0, 0, 0, "R4");
        // Probe without recency update does not save the oldest (R7).
        do_lookup('h10, 'h0, 1, 0, 0, 0, 0, 0, "R7");
        do_insert('h20, 1, 'h220, 1, 1);
        do_lookup('h10, 'h0, 1, 1, 0, 0, 0, 0, "R7");
        // Recency update does save it; next oldest is evicted (R7, R4).
        do_lookup('h14, 'h0, 1, 1, 0, 0, 0, 0, "R7");
        do_insert('h24, 1, 'h224, 1, 1);
        do_lookup('h14, 'h0, 1, 1, 0, 0, 0, 0, "R7");
        do_lookup('h18, 'h0, 1, 1, 0, 0, 0, 0, "R4");
        // Fills into set 1 never disturb set 0 (R1).
        for (int k = 0; k < 6; k++) do_insert('h11 + 4 * k, 1, 'h300 + k, 1, 1);
        do_lookup('h1C, 'h0, 1, 1, 0, 0, 0, 0, "R1");
        do_lookup('h20, 'h0, 1, 1, 0, 0, 0, 0, "R1");
        do_lookup('h24, 'h0, 1, 1, 0, 0, 0, 0, "R1");
        do_lookup('h25, 'h0, 1, 1, 0, 0, 0, 0, "R1");
        // Protection (R10).
        do_insert('h42, 0, 'h042, 0, 1);
        do_lookup('h42, 'h10, 0, 1, 0, 3, 0, 0, "R10");
        do_lookup('h42, 'h10, 0, 1, 0, 3, 1, 0, "R10");
        do_lookup('h42, 'h10, 0, 1, 0, 0, 0, 0, "R10");
        do_insert('h46, 0, 'h046, 1, 0);
        do_lookup('h46, 'h20, 0, 1, 1, 0, 0, 0, "R10");
        do_lookup('h46, 'h20, 0, 1, 0, 3, 0, 0, "R10");
        // Prefetch skips the check (R11).
        do_lookup('h42, 'h30, 0, 1, 0, 3, 0, 1, "R11");
        do_lookup('h46, 'h30, 0, 1, 1, 3, 0, 1, "R11");
        // Flush empties everything (R8).
        do_flush();
        do_lookup('h1C, 'h0, 1, 1, 0, 0, 0, 0, "R8");
        do_lookup('h42, 'h0, 0, 1, 0, 0, 0, 0, "R8");
        // Flush beats a same-cycle fill (R8).
        flush = 1'b1; ins_valid = 1'b1; ins_vpn = 20'h50; ins_pid = 4'd1;
        ins_pfn = 20'h550; ins_user_ok = 1'b1; ins_wr_ok = 1'b1;
        @(posedge clk);
        mq.delete();
        @(negedge clk);
        flush = 1'b0; ins_valid = 1'b0;
        do_lookup('h50, 'h0, 1, 1, 0, 0, 0, 0, "R8");
        do_insert('h50, 1, 'h550, 1, 1);
        do_lookup('h50, 'h7, 1, 1, 0, 0, 0, 0, "R8");

        // Mixed traffic against the model (R1, R2, R4, R7, R10, R11).
        for (int n = 0; n < 400; n++) begin
            int op;
            int vpn;
            int pid;
            op  = int'($urandom_range(0, 19));
            vpn = int'($urandom_range(0, 23));
            pid = int'($urandom_range(0, 1));
            if (op == 0) begin
                do_flush();
            end else if (op < 8) begin
                do_insert(vpn, pid, int'($urandom_range(0, 1023)),
                          1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)));
            end else begin
                do_lookup(vpn, int'($urandom_range(0, 4095)), pid,
                          1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
                          int'($urandom_range(0, 3)), 1'($urandom_range(0, 1)),
                          1'($urandom_range(0, 3) == 0), "R4");
            end
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule